// File: doc/BRIEF.md
# Transmit Block Gearbox (66-bit / 67-bit)

This block sits between fabric logic that produces scrambled 64-bit payloads and a fixed-width serializer. With each payload the fabric supplies a short sync header: two bits for 66-bit blocks, three bits for 67-bit blocks. The gearbox puts the header in front of the payload and repacks the resulting blocks into a continuous stream of serializer words. It produces one word on every clock once the stream has started. Header and payload bits are not altered. The block does not scramble, does not generate headers and does not serialize.

The user data path is either 2 or 4 bytes wide. The serializer word has the same width as the user data path. Because every block is longer than its payload, the stream gains bits over time. The gearbox therefore drops a ready output on the cycles where the fabric must hold back, so that the accumulated surplus drains. The fabric keeps its own free-running sequence count. It starts the stream by presenting the first word of a block together with a start flag and a sequence value of zero. Two static mode inputs select the block format and the data width. Both are held constant while reset is released.

Top module: `gearbox_tx`

## Requirements
- R1: With `fmt_67`=0 each block is `hdr_in[1:0]` followed by 64 payload bits. With `fmt_67`=1 it is `hdr_in[2:0]` followed by 64 payload bits. The header is taken on the first word of each block, and `hdr_in[2]` has no effect in 66-bit mode.
- R2: With `wide`=1 all 32 bits of `data_in` are used and a block takes 2 words. With `wide`=0 only `data_in[15:0]` is used, a block takes 4 words, and `word_out[31:16]` stays 0.
- R3: Bit order is least significant first: header bit 0 first, then `data_in` bit 0 upward. `word_out[0]` is the earliest bit of each output word.
- R4: After reset `ready` and `word_out` are 0, and they stay 0 until a start word is accepted.
- R5: A start word is accepted only when `start_seq`=1 and the used sequence bits are all zero. The used bits are `seq_in[5:0]` in 66-bit mode and `seq_in[6:0]` in 67-bit mode. That cycle's data is the first word of a block. Once the stream runs, `start_seq` has no effect.
- R6: From the cycle after the start word, `word_out` carries a new word of the stream on every clock, with no gap and no repeated bits.
- R7: In 66-bit mode, every 33-cycle period that begins at the start cycle has exactly one cycle with `ready`=0. That cycle is at offset 31 with `wide`=1 and at offset 29 with `wide`=0.
- R8: In 67-bit mode, every 67-cycle period that begins at the start cycle has exactly 3 cycles with `ready`=0 and 64 with `ready`=1.
- R9: `data_in` and `hdr_in` are ignored on cycles with `ready`=0, and `hdr_in` is ignored on words other than the first word of a block.
- R10: `ready` is never 0 on two consecutive cycles while the stream runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_67 | input | 1 | 0: 2-bit header blocks, 1: 3-bit header blocks |
| wide | input | 1 | 0: 2-byte words, 1: 4-byte words |
| data_in | input | 32 | Payload word from fabric |
| hdr_in | input | 3 | Sync header for the block being started |
| seq_in | input | 7 | Fabric sequence count |
| start_seq | input | 1 | Marks the first word after reset |
| ready | output | 1 | 1: a data word is taken this cycle |
| word_out | output | 32 | Serializer word |

## Verification
`ready` is formed from registered state. It is therefore valid during the cycle it refers to, and the bench reads it at the falling edge before it drives that cycle's data. Each word that is taken or emitted at a rising edge shows up on `word_out` one cycle later. The bench model pops the expected word at the edge that emits it and compares it at the next falling edge. The pause positions and the pause counts are checked at the close of every 33- or 67-cycle period, counted from the start cycle.

// File: rtl/gearbox_tx_pkg.sv
package gearbox_tx_pkg;

   typedef enum logic {
      FMT_66 = 1'b0,
      FMT_67 = 1'b1
   } blk_fmt_e;

   // header bits carried by each block format
   function automatic int unsigned hdr_bits(blk_fmt_e f);
      return (f == FMT_67) ? 3 : 2;
   endfunction

endpackage

// File: rtl/gearbox_tx_ctrl.sv
module gearbox_tx_ctrl
   import gearbox_tx_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned HDR_W     = 3,
   parameter int unsigned SEQ_W     = 7,
   parameter int unsigned PAYLOAD_W = 64,
   parameter int unsigned FILL_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  blk_fmt_e          fmt,
   input  logic              wide,
   input  logic              start_seq,
   input  logic [SEQ_W-1:0]  seq_in,
   output logic              ready,
   output logic              take,
   output logic              first,
   output logic              emit,
   output logic [FILL_W-1:0] fill_q,
   output logic [FILL_W-1:0] w_len,
   output logic [FILL_W-1:0] h_len
);

   localparam int unsigned HALF_W    = DW / 2;
   localparam int unsigned WORDS_MAX = PAYLOAD_W / HALF_W;
   localparam int unsigned WCNT_W    = (WORDS_MAX > 1) ? $clog2(WORDS_MAX) : 1;

   if ((PAYLOAD_W % DW) != 0 || (DW % 16) != 0) begin : g_bad_width
      $error("gearbox_tx_ctrl: payload must be a multiple of the word width");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("gearbox_tx_ctrl: sequence width too small");
   end

   logic              running_q;
   logic [WCNT_W-1:0] wcnt_q;
   logic [WCNT_W-1:0] last_word;
   logic [SEQ_W-1:0]  seq_used;
   logic              start_ok;

   always_comb begin
      w_len     = wide ? FILL_W'(DW) : FILL_W'(HALF_W);
      h_len     = FILL_W'(hdr_bits(fmt));
      last_word = wide ? WCNT_W'(PAYLOAD_W / DW - 1) : WCNT_W'(PAYLOAD_W / HALF_W - 1);
      seq_used  = seq_in;
      if (fmt == FMT_66) begin
         seq_used[SEQ_W-1] = 1'b0;
      end
      start_ok  = start_seq && (seq_used == '0);
      ready     = running_q && (fill_q < w_len);
      take      = ready || (!running_q && start_ok);
      first     = take && (wcnt_q == '0);
      emit      = running_q || take;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         fill_q    <= '0;
         wcnt_q    <= '0;
      end else begin
         if (take && !running_q) begin
            running_q <= 1'b1;
         end
         if (emit) begin
            fill_q <= fill_q + (take ? (w_len + (first ? h_len : '0)) : '0) - w_len;
         end
         if (take) begin
            wcnt_q <= (wcnt_q == last_word) ? '0 : wcnt_q + 1'b1;
         end
      end
   end

   AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !running_q |-> (fill_q == '0 && wcnt_q == '0)) else $error("idle state not clear"); // R4
   AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && start_ok) |=> running_q) else $error("start word not accepted"); // R5
   AST_NO_DOUBLE_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !ready) |=> ready) else $error("two pauses in a row"); // R10
   AST_EVEN_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_66) |-> !fill_q[0]) else $error("odd residue in 66-bit mode"); // R7
   AST_RESIDUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q < (w_len + h_len)) else $error("residue over bound"); // R6

endmodule

// File: rtl/gearbox_tx_pack.sv
module gearbox_tx_pack
   import gearbox_tx_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned HDR_W  = 3,
   parameter int unsigned FILL_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic [DW-1:0]     data_in,
   input  logic [HDR_W-1:0]  hdr_in,
   input  logic              take,
   input  logic              first,
   input  logic              emit,
   input  logic [FILL_W-1:0] fill_q,
   input  logic [FILL_W-1:0] w_len,
   input  logic [FILL_W-1:0] h_len,
   output logic [DW-1:0]     word_q
);

   localparam int unsigned LANES = DW / 8;
   localparam int unsigned BUF_W = 2 * DW + HDR_W;

   if (BUF_W >= (1 << FILL_W)) begin : g_bad_fill
      $error("gearbox_tx_pack: fill counter too narrow");
   end

   logic [LANES-1:0] lane_on;
   logic [DW-1:0]    data_m;
   logic [DW-1:0]    out_mask;
   logic [HDR_W-1:0] hdr_m;
   logic [BUF_W-1:0] vec;
   logic [BUF_W-1:0] merged;
   logic [BUF_W-1:0] res_q;

   // lower half lanes always on, upper half follows the width mode
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      if (b < LANES / 2) begin : g_low
         assign lane_on[b] = 1'b1;
      end else begin : g_high
         assign lane_on[b] = wide;
      end
      assign data_m[b*8 +: 8]   = lane_on[b] ? data_in[b*8 +: 8] : 8'h00;
      assign out_mask[b*8 +: 8] = {8{lane_on[b]}};
   end

   always_comb begin
      for (int i = 0; i < HDR_W; i++) begin
         hdr_m[i] = hdr_in[i] & (FILL_W'(i) < h_len);
      end
      if (first) begin
         vec = (BUF_W'(data_m) << h_len) | BUF_W'(hdr_m);
      end else begin
         vec = BUF_W'(data_m);
      end
      merged = res_q | (take ? (vec << fill_q) : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         word_q <= '0;
      end else if (emit) begin
         word_q <= merged[DW-1:0] & out_mask;
         res_q  <= merged >> w_len;
      end
   end

   AST_RESIDUE_ABOVE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (res_q >> fill_q) == '0) else $error("stale bits above residue level"); // R3

endmodule

// File: rtl/gearbox_tx.sv
module gearbox_tx
   import gearbox_tx_pkg::*;
#(
   parameter int unsigned LANE_BYTES = 4,
   parameter int unsigned HDR_W      = 3,
   parameter int unsigned SEQ_W      = 7,
   parameter int unsigned PAYLOAD_W  = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fmt_67,
   input  logic                    wide,
   input  logic [LANE_BYTES*8-1:0] data_in,
   input  logic [HDR_W-1:0]        hdr_in,
   input  logic [SEQ_W-1:0]        seq_in,
   input  logic                    start_seq,
   output logic                    ready,
   output logic [LANE_BYTES*8-1:0] word_out
);

   localparam int unsigned DW     = LANE_BYTES * 8;
   localparam int unsigned BUF_W  = 2 * DW + HDR_W;
   localparam int unsigned FILL_W = $clog2(BUF_W + 1);

   if (HDR_W != 3) begin : g_bad_hdr
      $error("gearbox_tx: header input must be 3 bits");
   end
   if (LANE_BYTES < 2 || (LANE_BYTES % 2) != 0) begin : g_bad_lanes
      $error("gearbox_tx: lane count must be even");
   end

   blk_fmt_e          fmt;
   logic              take;
   logic              first;
   logic              emit;
   logic [FILL_W-1:0] fill_q;
   logic [FILL_W-1:0] w_len;
   logic [FILL_W-1:0] h_len;

   assign fmt = fmt_67 ? FMT_67 : FMT_66;

   gearbox_tx_ctrl #(
      .DW(DW), .HDR_W(HDR_W), .SEQ_W(SEQ_W), .PAYLOAD_W(PAYLOAD_W), .FILL_W(FILL_W)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .wide(wide),
      .start_seq(start_seq), .seq_in(seq_in),
      .ready(ready), .take(take), .first(first), .emit(emit),
      .fill_q(fill_q), .w_len(w_len), .h_len(h_len)
   );

   gearbox_tx_pack #(
      .DW(DW), .HDR_W(HDR_W), .FILL_W(FILL_W)
   ) i_pack (
      .clk(clk), .rst_n(rst_n), .wide(wide),
      .data_in(data_in), .hdr_in(hdr_in),
      .take(take), .first(first), .emit(emit),
      .fill_q(fill_q), .w_len(w_len), .h_len(h_len),
      .word_q(word_out)
   );

   AST_NARROW_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wide |=> (word_out[DW-1:DW/2] == '0)) else $error("upper half active in narrow mode"); // R2

endmodule

// File: tb/test_gearbox_tx.sv
module test_gearbox_tx;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fmt_67 = 1'b0;
   logic        wide = 1'b1;
   logic [31:0] data_in = '0;
   logic [2:0]  hdr_in = '0;
   logic [6:0]  seq_in = '0;
   logic        start_seq = 1'b0;
   logic        ready;
   logic [31:0] word_out;

   int checks = 0;
   int errors = 0;
   bit q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   gearbox_tx i_gearbox_tx (
      .clk(clk), .rst_n(rst_n), .fmt_67(fmt_67), .wide(wide),
      .data_in(data_in), .hdr_in(hdr_in), .seq_in(seq_in),
      .start_seq(start_seq), .ready(ready), .word_out(word_out)
   );

   function automatic int pause_pos(bit wd);
      return wd ? 31 : 29;
   endfunction

   function automatic int period_len(bit f67);
      return f67 ? 67 : 33;
   endfunction

   function automatic int pauses_per_period(bit f67);
      return f67 ? 3 : 1;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic run_mode(bit f67, bit wd, int periods);
      int p = period_len(f67);
      int w = wd ? 32 : 16;
      int hb = f67 ? 3 : 2;
      int wpb = 64 / w;
      int wib = 0;
      int pos = 0;
      int pauses = 0;
      bit prev_rdy = 1'b1;
      bit tk;
      bit rdy;
      logic [31:0] exp_word = '0;
      fmt_67 = f67; wide = wd; rst_n = 1'b0;
      start_seq = 1'b0; seq_in = '0; data_in = '0; hdr_in = '0;
      q.delete();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ready == 1'b0, "R4 ready in reset", 32'(ready), 0);
      chk(word_out == '0, "R4 word in reset", word_out, 0);
      rst_n = 1'b1;
      repeat (3) begin
         data_in = $urandom; hdr_in = 3'($urandom);
         @(negedge clk);
         chk(ready == 1'b0, "R4 ready before start", 32'(ready), 0);
         chk(word_out == '0, "R4 word before start", word_out, 0);
      end
      // nonzero sequence must not start the stream
      start_seq = 1'b1; seq_in = 7'd5;
      @(negedge clk);
      @(negedge clk);
      chk(ready == 1'b0, "R5 start with nonzero seq", 32'(ready), 0);
      chk(word_out == '0, "R5 word after rejected start", word_out, 0);
      seq_in = 7'h40;
      if (f67) begin
         @(negedge clk);
         @(negedge clk);
         chk(ready == 1'b0, "R5 seq bit 6 counts in 67-bit mode", 32'(ready), 0);
         chk(word_out == '0, "R5 word after bit 6 start", word_out, 0);
         seq_in = 7'h00;
      end
      for (int c = 0; c <= periods * p; c++) begin
         pos = c % p;
         if (c > 0) begin
            chk(word_out == exp_word, "R1/R3/R6/R9 stream word", word_out, exp_word);
            if (!wd) chk(word_out[31:16] == '0, "R2 narrow upper half", word_out, {16'h0, exp_word[15:0]});
            rdy = ready;
            if (!f67) chk(rdy == (pos != pause_pos(wd)), "R7 pause position", 32'(rdy), 32'(pos != pause_pos(wd)));
            chk(rdy || prev_rdy, "R10 consecutive pauses", 32'(rdy), 1);
            prev_rdy = rdy;
            tk = rdy;
            if (!rdy) pauses++;
            start_seq = ($urandom % 4) == 0;
            seq_in = 7'(pos);
         end else begin
            tk = 1'b1;
         end
         data_in = $urandom;
         hdr_in = 3'($urandom);
         if (tk) begin
            if (wib == 0) for (int i = 0; i < hb; i++) q.push_back(hdr_in[i]);
            for (int i = 0; i < w; i++) q.push_back(data_in[i]);
            wib = (wib + 1) % wpb;
         end
         exp_word = '0;
         if (q.size() < w) begin
            chk(1'b0, "R6 model underflow", 32'(q.size()), 32'(w));
         end else begin
            for (int i = 0; i < w; i++) exp_word[i] = q.pop_front();
         end
         if (c > 0 && pos == p - 1) begin
            chk(pauses == pauses_per_period(f67), f67 ? "R8 pauses per period" : "R7 pauses per period",
                32'(pauses), 32'(pauses_per_period(f67)));
            pauses = 0;
         end
         @(negedge clk);
      end
      chk(word_out == exp_word, "R6 final word", word_out, exp_word);
      start_seq = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED));
      run_mode(1'b0, 1'b1, 4);
      run_mode(1'b0, 1'b0, 4);
      run_mode(1'b1, 1'b1, 3);
      run_mode(1'b1, 1'b0, 3);
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R6 watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

endmodule